// File: doc/BRIEF.md
# Effective Address Generator

This block turns the addressing-mode code of a small 8-bit processor with a 12-bit address space into three results. The first is the effective address of the operand. The second is the length of the instruction in bytes. The third is the address of the next instruction, which for a branch is the taken-branch target. Its inputs are the mode code, the two bytes that follow the opcode, the 8-bit index register and the address of the opcode. Opcode decoding, memory access and execution happen elsewhere.

The datapath is purely combinational. When the parameter `REG_OUT` is 1 (the default), all outputs pass through one register stage. The block covers ten modes: immediate, direct, extended, relative, three indexed variants, bit set/clear, bit test-and-branch and implied. The indexed variants differ in reach and in instruction length.

Top module: `eag_top`

## Requirements
- R1: Mode 0 (immediate): `ea_o` is the opcode address plus one, `imm_o` is 1 and `len_o` is 2.
- R2: Mode 1 (direct) and mode 7 (bit set/clear): `ea_o` is the zero-extended first byte and `len_o` is 2.
- R3: Mode 2 (extended): `ea_o` is the low 12 bits of {first byte, second byte}, with the first byte as the high half, and `len_o` is 3.
- R4: Mode 4 (indexed, no offset): `ea_o` is the zero-extended index register, so it never exceeds 0x0FF, and `len_o` is 1.
- R5: Mode 5 (indexed, 8-bit offset): `ea_o` is the index register plus the unsigned first byte, so it never exceeds 0x1FE, and `len_o` is 2.
- R6: Mode 6 (indexed, 16-bit offset): `ea_o` is ({first byte, second byte} + index register) modulo 4096, and `len_o` is 3.
- R7: Mode 3 (relative): `target_o` is (opcode address + 2 + sign-extended first byte) modulo 4096, `ea_o` equals that target, and `len_o` is 2.
- R8: Mode 8 (bit test-and-branch): `ea_o` is the zero-extended first byte, `len_o` is 3, and `target_o` is (opcode address + 3 + sign-extended second byte) modulo 4096.
- R9: In every mode other than 3 and 8, `target_o` is (opcode address + `len_o`) modulo 4096.
- R10: Mode 9 (implied) and the unused codes 10 to 15: `ea_o` is 0, `imm_o` is 0 and `len_o` is 1.
- R11: `imm_o` is 1 only for mode 0.
- R12: With `REG_OUT` = 1, each output shows the result for the inputs present at the previous rising clock edge. A low `rst_n` at a rising edge clears all outputs to zero; the reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Addressing-mode code |
| byte1_i | input | 8 | First byte after the opcode |
| byte2_i | input | 8 | Second byte after the opcode |
| x_i | input | 8 | Index register |
| pc_i | input | 12 | Address of the opcode |
| ea_o | output | 12 | Effective address |
| imm_o | output | 1 | Operand is the immediate byte |
| len_o | output | 2 | Instruction length in bytes |
| target_o | output | 12 | Next-instruction or branch-target address |

## Verification
With the default register stage, all four results are due one rising edge after the inputs are applied. The bench drives inputs on the falling edge and reads the results on the next falling edge, half a cycle after the register has loaded them. A directed check also reads the outputs right after new inputs are driven and before any edge, to show that they still hold the previous result. The reset test lowers `rst_n` the same way: the outputs must keep their values until the next rising edge and read zero after it.

// File: rtl/eag_pkg.sv
// Shared types for the effective address generator.
// Assumes a 4-bit mode code; codes above MODE_INH are unused.
package eag_pkg;

    typedef enum logic [3:0] {
        MODE_IMM = 4'd0,
        MODE_DIR = 4'd1,
        MODE_EXT = 4'd2,
        MODE_REL = 4'd3,
        MODE_IX0 = 4'd4,
        MODE_IX1 = 4'd5,
        MODE_IX2 = 4'd6,
        MODE_BSC = 4'd7,
        MODE_BTB = 4'd8,
        MODE_INH = 4'd9
    } mode_e;

    // Which byte, if any, carries a signed branch displacement
    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_B1   = 2'd1,
        BR_B2   = 2'd2
    } br_sel_e;

endpackage

// File: rtl/eag_len_decode.sv
// Instruction length, immediate flag and displacement-byte select per mode.
// Assumes the mode code is stable for the whole evaluation; purely combinational.
module eag_len_decode
    import eag_pkg::*;
#(
    parameter int LEN_W = 2
) (
    input  logic [3:0]       mode_i,
    output logic [LEN_W-1:0] len_o,
    output logic             imm_o,
    output br_sel_e          br_o
);

    // Map each mode to its byte count and branch displacement source
    always_comb begin
        len_o = LEN_W'(1);
        imm_o = 1'b0;
        br_o  = BR_NONE;
        case (mode_i)
            MODE_IMM: begin len_o = LEN_W'(2); imm_o = 1'b1; end
            MODE_DIR: len_o = LEN_W'(2);
            MODE_EXT: len_o = LEN_W'(3);
            MODE_REL: begin len_o = LEN_W'(2); br_o = BR_B1; end
            MODE_IX0: len_o = LEN_W'(1);
            MODE_IX1: len_o = LEN_W'(2);
            MODE_IX2: len_o = LEN_W'(3);
            MODE_BSC: len_o = LEN_W'(2);
            MODE_BTB: begin len_o = LEN_W'(3); br_o = BR_B2; end
            default:  len_o = LEN_W'(1);
        endcase
    end

endmodule

// File: rtl/eag_index_unit.sv
// Address sums for the three indexed modes.
// Assumes 2*DATA_W >= ADDR_W; the 16-bit form wraps modulo 2**ADDR_W.
module eag_index_unit #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] b1_i,
    input  logic [DATA_W-1:0] b2_i,
    output logic [ADDR_W-1:0] ix0_o,
    output logic [ADDR_W-1:0] ix1_o,
    output logic [ADDR_W-1:0] ix2_o
);

    localparam int SUM1_W = DATA_W + 1;

    logic [SUM1_W-1:0] sum1;
    logic [ADDR_W-1:0] wide_off;

    // No-offset form: the index register alone, zero-extended
    assign ix0_o = ADDR_W'(x_i);

    // 8-bit offset form: unsigned sum kept one bit wider than the operands
    always_comb begin
        sum1  = SUM1_W'(x_i) + SUM1_W'(b1_i);
        ix1_o = ADDR_W'(sum1);
    end

    // 16-bit offset form: two bytes form the base, sum truncated to the space
    always_comb begin
        wide_off = ADDR_W'({b1_i, b2_i});
        ix2_o    = wide_off + ADDR_W'(x_i);
    end

endmodule

// File: rtl/eag_branch_unit.sv
// Next-instruction address and branch target.
// Assumes pc_i is the opcode address; all sums wrap modulo 2**ADDR_W.
module eag_branch_unit
    import eag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] b1_i,
    input  logic [DATA_W-1:0] b2_i,
    input  br_sel_e           br_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] disp;
    logic [ADDR_W-1:0] disp_sx;
    logic [ADDR_W-1:0] next_pc;

    // Pick the displacement byte and sign-extend it to the address width
    always_comb begin
        disp    = (br_i == BR_B2) ? b2_i : b1_i;
        disp_sx = {{EXT_W{disp[DATA_W-1]}}, disp};
    end

    // Next instruction, plus the displacement when the mode branches
    always_comb begin
        next_pc  = pc_i + ADDR_W'(len_i);
        target_o = (br_i == BR_NONE) ? next_pc : next_pc + disp_sx;
    end

endmodule

// File: rtl/eag_ea_select.sv
// Chooses the effective address for the current mode.
// Assumes the index sums and branch target are already valid; combinational.
module eag_ea_select
    import eag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] b1_i,
    input  logic [DATA_W-1:0] b2_i,
    input  logic [ADDR_W-1:0] ix0_i,
    input  logic [ADDR_W-1:0] ix1_i,
    input  logic [ADDR_W-1:0] ix2_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] ea_o
);

    logic [ADDR_W-1:0] direct_ea;
    logic [ADDR_W-1:0] ext_ea;
    logic [ADDR_W-1:0] imm_ea;

    // Candidate addresses that need no index arithmetic
    always_comb begin
        direct_ea = ADDR_W'(b1_i);
        ext_ea    = ADDR_W'({b1_i, b2_i});
        imm_ea    = pc_i + ADDR_W'(1);
    end

    // Mode multiplexer; implied and unused codes give address zero
    always_comb begin
        case (mode_i)
            MODE_IMM: ea_o = imm_ea;
            MODE_DIR: ea_o = direct_ea;
            MODE_EXT: ea_o = ext_ea;
            MODE_REL: ea_o = target_i;
            MODE_IX0: ea_o = ix0_i;
            MODE_IX1: ea_o = ix1_i;
            MODE_IX2: ea_o = ix2_i;
            MODE_BSC: ea_o = direct_ea;
            MODE_BTB: ea_o = direct_ea;
            default:  ea_o = '0;
        endcase
    end

endmodule

// File: rtl/eag_top.sv
// Effective address generator top: length decode, index sums, branch target,
// address select and an optional output register stage (REG_OUT).
// Assumes synchronous active-low reset; outputs are zero while in reset.
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic [DATA_W-1:0] byte1_i,
    input  logic [DATA_W-1:0] byte2_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              imm_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam logic [ADDR_W-1:0] IX0_MAX = ADDR_W'((1 << DATA_W) - 1);
    localparam logic [ADDR_W-1:0] IX1_MAX = ADDR_W'(2 * ((1 << DATA_W) - 1));

    logic [LEN_W-1:0]  len_c;
    logic              imm_c;
    br_sel_e           br_c;
    logic [ADDR_W-1:0] ix0_c, ix1_c, ix2_c;
    logic [ADDR_W-1:0] tgt_c;
    logic [ADDR_W-1:0] ea_c;

    eag_len_decode #(.LEN_W(LEN_W)) u_len (
        .mode_i (mode_i),
        .len_o  (len_c),
        .imm_o  (imm_c),
        .br_o   (br_c)
    );

    eag_index_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idx (
        .x_i   (x_i),
        .b1_i  (byte1_i),
        .b2_i  (byte2_i),
        .ix0_o (ix0_c),
        .ix1_o (ix1_c),
        .ix2_o (ix2_c)
    );

    eag_branch_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_br (
        .pc_i     (pc_i),
        .len_i    (len_c),
        .b1_i     (byte1_i),
        .b2_i     (byte2_i),
        .br_i     (br_c),
        .target_o (tgt_c)
    );

    eag_ea_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .mode_i   (mode_i),
        .pc_i     (pc_i),
        .b1_i     (byte1_i),
        .b2_i     (byte2_i),
        .ix0_i    (ix0_c),
        .ix1_i    (ix1_c),
        .ix2_i    (ix2_c),
        .target_i (tgt_c),
        .ea_o     (ea_c)
    );

    // Assertions on the combinational results, checked at each clock edge
    AST_IMM_ONLY_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        imm_c |-> (mode_i == MODE_IMM));                                    // R11
    AST_IX0_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IX0) |-> (ea_c <= IX0_MAX && len_c == LEN_W'(1)));  // R4
    AST_IX1_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IX1) |-> (ea_c <= IX1_MAX && len_c == LEN_W'(2)));  // R5
    AST_UNUSED_AS_IMPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i >= 4'd9) |-> (ea_c == '0 && !imm_c && len_c == LEN_W'(1))); // R10
    AST_REL_EA_IS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_REL) |-> (ea_c == tgt_c));                          // R7

    generate
        if (REG_OUT) begin : g_reg
            logic past_run;

            // Output register stage with synchronous clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ea_o     <= '0;
                    imm_o    <= 1'b0;
                    len_o    <= '0;
                    target_o <= '0;
                end else begin
                    ea_o     <= ea_c;
                    imm_o    <= imm_c;
                    len_o    <= len_c;
                    target_o <= tgt_c;
                end
            end

            // Records that the previous edge was outside reset
            always_ff @(posedge clk) begin
                past_run <= rst_n;
            end

            AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                past_run |-> (ea_o == $past(ea_c) && len_o == $past(len_c)
                              && target_o == $past(tgt_c) && imm_o == $past(imm_c))); // R12
            AST_CLEARED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
                !past_run |-> (ea_o == '0 && len_o == '0 && target_o == '0 && !imm_o)); // R12
        end else begin : g_comb
            // Direct combinational outputs
            always_comb begin
                ea_o     = ea_c;
                imm_o    = imm_c;
                len_o    = len_c;
                target_o = tgt_c;
            end
        end
    endgenerate

endmodule

// File: tb/eag_top_test.sv
`timescale 1ns/1ps
module eag_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [7:0]  byte1_i = '0;
    logic [7:0]  byte2_i = '0;
    logic [7:0]  x_i = '0;
    logic [11:0] pc_i = '0;
    logic [11:0] ea_o;
    logic        imm_o;
    logic [1:0]  len_o;
    logic [11:0] target_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    eag_top uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .byte1_i(byte1_i),
        .byte2_i(byte2_i), .x_i(x_i), .pc_i(pc_i), .ea_o(ea_o),
        .imm_o(imm_o), .len_o(len_o), .target_o(target_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  mode;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  x;
        logic [11:0] pc;
        logic [11:0] ea;
        logic        imm;
        logic [1:0]  len;
        logic [11:0] tgt;
    } vec_t;

    localparam int NV = 18;
    // req, mode, b1, b2, x, pc -> ea, imm, len, target
    localparam vec_t VECS [NV] = '{
        '{8'd1,  4'd0, 8'h5A, 8'h00, 8'h00, 12'h100, 12'h101, 1'b1, 2'd2, 12'h102}, // R1
        '{8'd2,  4'd1, 8'hC3, 8'h00, 8'h11, 12'h200, 12'h0C3, 1'b0, 2'd2, 12'h202}, // R2 direct
        '{8'd3,  4'd2, 8'h0A, 8'hBC, 8'h00, 12'h010, 12'hABC, 1'b0, 2'd3, 12'h013}, // R3
        '{8'd3,  4'd2, 8'hF1, 8'h23, 8'h00, 12'hFFE, 12'h123, 1'b0, 2'd3, 12'h001}, // R3 truncation, R9 wrap
        '{8'd7,  4'd3, 8'h10, 8'h00, 8'h00, 12'h300, 12'h312, 1'b0, 2'd2, 12'h312}, // R7 forward
        '{8'd7,  4'd3, 8'hFE, 8'h00, 8'h00, 12'h300, 12'h300, 1'b0, 2'd2, 12'h300}, // R7 backward
        '{8'd7,  4'd3, 8'h80, 8'h00, 8'h00, 12'h010, 12'hF92, 1'b0, 2'd2, 12'hF92}, // R7 wrap below zero
        '{8'd4,  4'd4, 8'h33, 8'h44, 8'hFF, 12'h400, 12'h0FF, 1'b0, 2'd1, 12'h401}, // R4
        '{8'd5,  4'd5, 8'hFF, 8'h00, 8'hFF, 12'h400, 12'h1FE, 1'b0, 2'd2, 12'h402}, // R5 reach limit
        '{8'd6,  4'd6, 8'h0F, 8'hFF, 8'h01, 12'h500, 12'h000, 1'b0, 2'd3, 12'h503}, // R6 wrap
        '{8'd6,  4'd6, 8'h01, 8'h20, 8'h30, 12'h000, 12'h150, 1'b0, 2'd3, 12'h003}, // R6
        '{8'd6,  4'd6, 8'hF0, 8'h10, 8'hF0, 12'h000, 12'h100, 1'b0, 2'd3, 12'h003}, // R6 high nibble dropped
        '{8'd2,  4'd7, 8'h47, 8'h99, 8'h00, 12'h600, 12'h047, 1'b0, 2'd2, 12'h602}, // R2 bit set/clear
        '{8'd8,  4'd8, 8'h80, 8'h05, 8'h00, 12'h600, 12'h080, 1'b0, 2'd3, 12'h608}, // R8 forward
        '{8'd8,  4'd8, 8'h12, 8'hFD, 8'h00, 12'h600, 12'h012, 1'b0, 2'd3, 12'h600}, // R8 backward
        '{8'd10, 4'd9, 8'hAA, 8'hBB, 8'h77, 12'h7FF, 12'h000, 1'b0, 2'd1, 12'h800}, // R10 implied
        '{8'd10, 4'hC, 8'h55, 8'h66, 8'h12, 12'h7FF, 12'h000, 1'b0, 2'd1, 12'h800}, // R10 unused code
        '{8'd10, 4'hF, 8'hFF, 8'hFF, 8'hFF, 12'hFFF, 12'h000, 1'b0, 2'd1, 12'h000}  // R10, R9 wrap
    };

    task automatic check_out(input string tag, input logic [11:0] e_ea, input logic e_imm,
                             input logic [1:0] e_len, input logic [11:0] e_tgt);
        checks++;
        if (ea_o !== e_ea || imm_o !== e_imm || len_o !== e_len || target_o !== e_tgt) begin
            errors++;
            $display("FAIL %s: ea=%h imm=%b len=%0d tgt=%h expected ea=%h imm=%b len=%0d tgt=%h",
                     tag, ea_o, imm_o, len_o, target_o, e_ea, e_imm, e_len, e_tgt);
        end
    endtask

    task automatic drive(input vec_t v);
        mode_i = v.mode; byte1_i = v.b1; byte2_i = v.b2; x_i = v.x; pc_i = v.pc;
    endtask

    initial begin
        // R12: outputs cleared while reset is held
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R12 reset state", 12'h000, 1'b0, 2'd0, 12'h000);
        rst_n = 1'b1;

        // Table walk: drive on a falling edge, read one rising edge later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                      VECS[i].ea, VECS[i].imm, VECS[i].len, VECS[i].tgt);
        end

        // R12: new inputs do not reach the outputs before the next rising edge
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[13]);
        #0.5;
        check_out("R12 hold before edge", VECS[0].ea, VECS[0].imm, VECS[0].len, VECS[0].tgt);
        @(negedge clk);
        check_out("R12 after edge", VECS[13].ea, VECS[13].imm, VECS[13].len, VECS[13].tgt);

        // R11: immediate flag drops when leaving mode 0
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[1]);
        @(negedge clk);
        check_out("R11 flag cleared", VECS[1].ea, 1'b0, VECS[1].len, VECS[1].tgt);

        // R12: reset is synchronous, outputs clear only at the edge
        drive(VECS[2]);
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check_out("R12 sync reset before edge", VECS[2].ea, VECS[2].imm, VECS[2].len, VECS[2].tgt);
        @(negedge clk);
        check_out("R12 sync reset after edge", 12'h000, 1'b0, 2'd0, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R3 after reset release", VECS[2].ea, VECS[2].imm, VECS[2].len, VECS[2].tgt);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule